// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. Either of two address strobes captures a full external address. The processor-side strobe takes its address from `addr_cpu`, and the controller-side strobe takes its address from `addr_ctl`. After that load, each cycle in which `advance` is high moves the two low address bits to the next beat of a four-word burst. All other address bits stay fixed, so the burst stays inside its aligned group of four words. The burst is optional: a new address can be strobed in on every clock with no idle cycle.

The order of the low bits is chosen when the address is loaded:

- **Linear order** counts upward from the start word and wraps.
- **Interleaved order** XORs the start word with the beat number.

The order input is active-high for linear order. Driving it low, or tying it low, gives interleaved order, which is the default.

Every input is sampled on the rising clock edge. The address and beat index are registered, so they change one cycle after the edge that sampled the command.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `word_addr` is 0 and `beat_idx` is 0.
- R2: A rising edge with `strobe_cpu` high loads `addr_cpu`. In the next cycle `word_addr` equals the sampled `addr_cpu` and `beat_idx` is 0.
- R3: A rising edge with `strobe_ctl` high and `strobe_cpu` low loads `addr_ctl` in the same way.
- R4: When both strobes are high at the same edge, `addr_cpu` is loaded and `addr_ctl` is ignored.
- R5: A strobe at an edge overrides `advance` at that edge. The loaded address appears with `beat_idx` 0.
- R6: If `lin_order` was 1 at the load edge, beat n drives the low two bits of `word_addr` to (start + n) mod 4.
- R7: If `lin_order` was 0 at the load edge, beat n drives the low two bits to start XOR n. Holding `lin_order` at 0 therefore gives interleaved order by default.
- R8: An edge with `advance` high and no strobe increments `beat_idx` modulo 4. `word_addr` bits above bit 1 do not change.
- R9: An edge with no strobe and `advance` low leaves `word_addr` and `beat_idx` unchanged.
- R10: After four advances, `word_addr` returns to the start word and `beat_idx` returns to 0.
- R11: Changing `lin_order` between loads has no effect on the running burst. The order captured at the load edge stays in force until the next load.
- R12: Strobes on consecutive edges load a new address on each edge, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lin_order | input | 1 | 1 = linear beat order, 0 = interleaved (default) |
| strobe_cpu | input | 1 | Processor-side address strobe, higher priority |
| strobe_ctl | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step to the next beat when no strobe is present |
| addr_cpu | input | ADDR_W | Address loaded by `strobe_cpu` |
| addr_ctl | input | ADDR_W | Address loaded by `strobe_ctl` |
| word_addr | output | ADDR_W | Current word address |
| beat_idx | output | BEAT_W | Beat number within the current burst |

## Verification
The bench builds the block with `ADDR_W` = 12 and the default `BEAT_W` = 2. The narrower address keeps expected values easy to read while still leaving ten upper bits. Those upper bits are checked to stay fixed through a burst and through wrap-around.

With a two-bit beat, every one of the four start words can be run in both orders. This gives full coverage of both sequence tables, including the wrap back to the start word.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lin_order,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr_cpu,
  input  logic [ADDR_W-1:0] addr_ctl,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BEAT_W-1:0] beat_idx
);

  logic              load;
  logic [ADDR_W-1:0] load_addr;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              lin_q;
  logic [BEAT_W-1:0] low_bits;

  assign load      = strobe_cpu | strobe_ctl;
  assign load_addr = strobe_cpu ? addr_cpu : addr_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      lin_q  <= 1'b0;
    end else if (load) begin
      base_q <= load_addr;
      beat_q <= '0;
      lin_q  <= lin_order;
    end else if (advance) begin
      beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign low_bits  = lin_q ? (base_q[BEAT_W-1:0] + beat_q)
                           : (base_q[BEAT_W-1:0] ^ beat_q);
  assign word_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};
  assign beat_idx  = beat_q;

  // R2
  cpu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_cpu |=> (word_addr == $past(addr_cpu)) && (beat_idx == '0));

  // R3
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ctl && !strobe_cpu) |=> (word_addr == $past(addr_ctl)) && (beat_idx == '0));

  // R8
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && advance) |=>
      (beat_idx == BEAT_W'($past(beat_idx) + 1)) &&
      (word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && !advance) |=> $stable(word_addr) && $stable(beat_idx));

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lin_order = 1'b0;
  logic          strobe_cpu = 1'b0;
  logic          strobe_ctl = 1'b0;
  logic          advance = 1'b0;
  logic [AW-1:0] addr_cpu = '0;
  logic [AW-1:0] addr_ctl = '0;
  logic [AW-1:0] word_addr;
  logic [1:0]    beat_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .lin_order(lin_order),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .advance(advance),
    .addr_cpu(addr_cpu), .addr_ctl(addr_ctl),
    .word_addr(word_addr), .beat_idx(beat_idx)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, bit lin, int n);
    logic [1:0] lo;
    lo = lin ? 2'((s[1:0] + n) & 3) : (s[1:0] ^ 2'(n));
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] ea, logic [1:0] eb);
    checks++;
    if (word_addr !== ea || beat_idx !== eb) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, word_addr, beat_idx, ea, eb);
    end
  endtask

  task automatic cyc(bit cpu, bit ctl, bit adv, logic [AW-1:0] ac, logic [AW-1:0] at, bit lin);
    @(negedge clk);
    strobe_cpu = cpu; strobe_ctl = ctl; advance = adv;
    addr_cpu = ac; addr_ctl = at; lin_order = lin;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", '0, 2'd0);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 0, 12'h5a5, 12'h3c3, 0);
    check("R1 after reset", '0, 2'd0);
  endtask

  task automatic t_burst(bit lin, string req);
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] a;
      a = 12'h7b0 | AW'(s);
      cyc(1, 0, 0, a, 12'h111, lin);
      check(req, a, 2'd0);
      for (int n = 1; n < 4; n++) begin
        cyc(0, 0, 1, 12'h000, 12'h000, lin);
        check(req, exp_addr(a, lin, n), 2'(n));
      end
      cyc(0, 0, 1, 12'h000, 12'h000, lin);
      check("R10 wrap", a, 2'd0);
    end
  endtask

  task automatic t_hold();
    cyc(1, 0, 0, 12'h9e1, 12'h000, 1);
    cyc(0, 0, 1, 12'h000, 12'h000, 1);
    check("R8 step", 12'h9e2, 2'd1);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 12'hfff, 12'hfff, 1);
      check("R9 hold", 12'h9e2, 2'd1);
    end
  endtask

  task automatic t_strobes();
    cyc(0, 1, 0, 12'h444, 12'h2c7, 0);
    check("R3 ctl load", 12'h2c7, 2'd0);
    cyc(1, 1, 0, 12'h613, 12'h0aa, 0);
    check("R4 cpu priority", 12'h613, 2'd0);
    cyc(0, 0, 1, 12'h000, 12'h000, 0);
    check("R2 cpu burst", 12'h612, 2'd1);
    cyc(0, 1, 1, 12'h000, 12'h8d2, 0);
    check("R5 strobe over advance", 12'h8d2, 2'd0);
    cyc(1, 0, 1, 12'h5b3, 12'h000, 0);
    check("R5 strobe over advance", 12'h5b3, 2'd0);
  endtask

  task automatic t_mode_latch();
    cyc(1, 0, 0, 12'h3a1, 12'h000, 0);
    cyc(0, 0, 1, 12'h000, 12'h000, 1);
    check("R11 order latched", 12'h3a0, 2'd1);
    cyc(0, 0, 1, 12'h000, 12'h000, 1);
    check("R11 order latched", 12'h3a3, 2'd2);
    cyc(1, 0, 0, 12'h3a1, 12'h000, 1);
    cyc(0, 0, 1, 12'h000, 12'h000, 0);
    check("R11 order latched", 12'h3a2, 2'd1);
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a;
      a = AW'(12'h101 * (k + 1));
      if (k % 2 == 0) begin
        cyc(1, 0, 1, a, 12'h000, k[0]);
      end else begin
        cyc(0, 1, 1, 12'h000, a, k[0]);
      end
      check("R12 every-cycle load", a, 2'd0);
    end
  endtask

  initial begin
    t_reset();
    t_burst(1'b1, "R6 linear");
    t_burst(1'b0, "R7 interleaved");
    t_hold();
    t_strobes();
    t_mode_latch();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule